// File: doc/BRIEF.md
# Programmable Flex Protocol Header Parser

This block is one parser node for a custom protocol header that a fixed decoder cannot recognise. Header bytes arrive one per cycle, with first-byte and last-byte markers. On the first byte the block also sees the type of the upstream parser node and the next-protocol value that the previous header carried. If an enabled input arc matches both, the node is active for this header. While the bytes stream past, it collects the words it needs: the length field, the next-header field and up to eight 32-bit flow-match samples. No copy of the whole header is kept.

One cycle after the last byte, the block works out the header length. It then decides which samples are valid, extracts the next-header type and resolves the next parser node through a prioritised set of output arcs. The outcome appears as a single-cycle result. Software sets the node up through a plain register write port. A write that arrives while a header is in flight is held and applied only after the packet ends, so one header is always parsed with one consistent setup.

Top module: `flex_hdr_parser`

## Requirements
- R1: The node becomes active for a header only if an enabled input arc has a node type equal to `up_node` and a compare value equal to `up_proto`, both sampled with the first byte. A header that does not activate the node produces no result (`res_v` stays low).
- R2: An arc is disabled when its node type is 0 or equals the flex node type itself (parameter `FLEX_NODE`, default 0xF0), and a disabled arc never matches. Arc register layout: bits [7:0] node type, bits [23:8] compare value.
- R3: Header length. Mode 1 (bits [23:20] of register 0) gives base + ((W & mask) >> shift). Any other mode gives the base alone. The base is in register 0 bits [15:0] and the shift in bits [19:16]. The mask is register 2. W is the 4-byte big-endian word that starts at the length offset (register 1 bits [15:0]).
- R4: A result pulses `res_v` for exactly one cycle, two clock edges after the edge that samples the last byte of an active header.
- R5: Sample slot i (register 24+i: bits [15:0] byte offset, bit 16 enable) reports the 4 header bytes at its offset, the first byte most significant, on `smp_data[32*i+31:32*i]`. Its sample ID is its slot index i.
- R6: `smp_v[i]` is set only when slot i is enabled and offset+4 does not exceed the header length. An invalid slot reports data 0.
- R7: The next-header type is the top S bits of the 4-byte big-endian word at the next-header offset (register 1 bits [31:16]), where S (register 3 bits [4:0], 1..16) is the field size. It is valid only when that offset+4 is within the header length. The lowest-numbered enabled output arc whose compare value equals the type wins; `res_hit` is set and `res_node` carries that arc's node type.
- R8: When no output arc is enabled, `res_last` is set and `res_hit` is clear.
- R9: If fewer bytes arrive than the header length, `res_err` is set and all of `smp_v`, `res_hit` and `res_last` are clear.
- R10: A configuration write that arrives during a packet, or together with its first byte, takes effect only after the last byte. The packet in flight is parsed with the old setup.
- R11: After reset and whenever `res_v` is low, all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header byte valid |
| hdr_sop | input | 1 | First byte of the header |
| hdr_eop | input | 1 | Last byte of the packet |
| hdr_byte | input | 8 | Header byte |
| up_node | input | 8 | Upstream parser node type, sampled with the first byte |
| up_proto | input | 16 | Previous header's next-protocol value, sampled with the first byte |
| res_v | output | 1 | Result valid pulse |
| res_err | output | 1 | Header shorter than its computed length |
| res_last | output | 1 | No output arc enabled: last header in the stack |
| res_hit | output | 1 | An output arc matched |
| res_node | output | 8 | Next parser node type |
| smp_v | output | 8 | Per-slot sample valid |
| smp_data | output | 256 | Sample words, slot i at bits [32*i+31:32*i] |

## Verification
The assertions assume that `hdr_sop` marks the first valid byte of every packet. They also assume that no packet starts before the previous one has ended, and that the inputs stay at zero while reset is asserted. The stimulus sends each packet as an unbroken run of bytes, followed by idle cycles. Configuration writes go only through the write port, and one of them is deliberately placed in the middle of a packet.

// File: rtl/flex_pkg.sv
package flex_pkg;
  typedef struct packed {
    logic [15:0] cmp;
    logic [7:0]  node;
  } arc_t;

  typedef struct packed {
    logic        en;
    logic [15:0] off;
  } smp_cfg_t;

  localparam logic [3:0] LEN_MODE_FIELD = 4'd1;
endpackage

// File: rtl/flex_word_tap.sv
module flex_word_tap #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_v,
  input  logic             sop,
  input  logic [CNT_W-1:0] idx,
  input  logic [15:0]      off,
  input  logic [7:0]       din,
  output logic [31:0]      word
);
  logic [31:0] word_q, word_d, base;
  logic        take;

  always_comb begin
    take   = byte_v && (33'(idx) >= 33'(off)) && (33'(idx) < 33'(off) + 33'd4);
    base   = (byte_v && sop) ? 32'd0 : word_q;
    word_d = take ? {base[23:0], din} : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (byte_v) word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/flex_arc_sel.sv
module flex_arc_sel import flex_pkg::*; #(
  parameter int         N         = 8,
  parameter logic [7:0] FLEX_NODE = 8'hF0
) (
  input  arc_t [N-1:0] arcs,
  input  logic         chk_node,
  input  logic [7:0]   key_node,
  input  logic [15:0]  key_cmp,
  output logic         hit,
  output logic [7:0]   sel_node,
  output logic         any_en
);
  logic [N-1:0] en, match;

  for (genvar g = 0; g < N; g++) begin : g_arc
    assign en[g]    = (arcs[g].node != 8'd0) && (arcs[g].node != FLEX_NODE);
    assign match[g] = en[g] && (arcs[g].cmp == key_cmp) &&
                      (!chk_node || (arcs[g].node == key_node));
  end

  always_comb begin
    hit      = 1'b0;
    sel_node = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        sel_node = arcs[i].node;
      end
    end
    any_en = |en;
  end
endmodule

// File: rtl/flex_cfg_bank.sv
module flex_cfg_bank import flex_pkg::*; #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_SMP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                we,
  input  logic [4:0]          addr,
  input  logic [31:0]         wdata,
  output logic [15:0]         len_base,
  output logic [3:0]          len_shift,
  output logic [3:0]          len_mode,
  output logic [15:0]         len_off,
  output logic [15:0]         nxt_off,
  output logic [31:0]         len_mask,
  output logic [4:0]          nxt_size,
  output arc_t [N_IN-1:0]     in_arcs,
  output arc_t [N_OUT-1:0]    out_arcs,
  output smp_cfg_t [N_SMP-1:0] smps
);
  logic        pend_v_q, pend_v_d, pend_ld;
  logic [4:0]  pend_a_q;
  logic [31:0] pend_d_q;
  logic        wr_go;
  logic [4:0]  wr_a;
  logic [31:0] wr_d;

  always_comb begin
    wr_a     = pend_v_q ? pend_a_q : addr;
    wr_d     = pend_v_q ? pend_d_q : wdata;
    wr_go    = !hold && (pend_v_q || we);
    pend_ld  = we && (hold || pend_v_q);
    pend_v_d = we ? (hold || pend_v_q) : (pend_v_q && hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_a_q <= '0;
      pend_d_q <= '0;
    end else begin
      pend_v_q <= pend_v_d;
      if (pend_ld) begin
        pend_a_q <= addr;
        pend_d_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_base <= '0; len_shift <= '0; len_mode <= '0;
      len_off  <= '0; nxt_off   <= '0; len_mask <= '0; nxt_size <= '0;
      in_arcs  <= '0; out_arcs  <= '0; smps     <= '0;
    end else if (wr_go) begin
      if (wr_a == 5'd0) begin
        len_base  <= wr_d[15:0];
        len_shift <= wr_d[19:16];
        len_mode  <= wr_d[23:20];
      end
      if (wr_a == 5'd1) begin
        len_off <= wr_d[15:0];
        nxt_off <= wr_d[31:16];
      end
      if (wr_a == 5'd2) len_mask <= wr_d;
      if (wr_a == 5'd3) nxt_size <= wr_d[4:0];
      for (int i = 0; i < N_IN; i++)
        if (wr_a == 5'(8 + i)) in_arcs[i] <= wr_d[23:0];
      for (int i = 0; i < N_OUT; i++)
        if (wr_a == 5'(16 + i)) out_arcs[i] <= wr_d[23:0];
      for (int i = 0; i < N_SMP; i++)
        if (wr_a == 5'(24 + i)) smps[i] <= wr_d[16:0];
    end
  end
endmodule

// File: rtl/flex_hdr_parser.sv
module flex_hdr_parser import flex_pkg::*; #(
  parameter int         N_IN      = 8,
  parameter int         N_OUT     = 8,
  parameter int         N_SMP     = 8,
  parameter int         CNT_W     = 16,
  parameter logic [7:0] FLEX_NODE = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [4:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               hdr_valid,
  input  logic               hdr_sop,
  input  logic               hdr_eop,
  input  logic [7:0]         hdr_byte,
  input  logic [7:0]         up_node,
  input  logic [15:0]        up_proto,
  output logic               res_v,
  output logic               res_err,
  output logic               res_last,
  output logic               res_hit,
  output logic [7:0]         res_node,
  output logic [N_SMP-1:0]   smp_v,
  output logic [N_SMP*32-1:0] smp_data
);
  localparam int SMP_W = N_SMP * 32;

  logic [15:0] len_base, len_off, nxt_off;
  logic [3:0]  len_shift, len_mode;
  logic [31:0] len_mask;
  logic [4:0]  nxt_size;
  arc_t [N_IN-1:0]      in_arcs;
  arc_t [N_OUT-1:0]     out_arcs;
  smp_cfg_t [N_SMP-1:0] smps;

  logic             in_pkt_q, in_pkt_d, act_q, act_d, fin_q, fin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             beat_ok, start, hold;
  logic             in_hit, out_hit, out_any;
  logic [7:0]       in_sel, out_sel;
  logic [31:0]      len_word, nxt_word, len_fld;
  logic [31:0]      smp_word [N_SMP];
  logic [32:0]      hlen;
  logic             short_hdr, nxt_rng;
  logic [15:0]      nxt_type;

  logic               res_v_d, res_err_d, res_last_d, res_hit_d;
  logic [7:0]         res_node_d;
  logic [N_SMP-1:0]   smp_v_d;
  logic [SMP_W-1:0]   smp_data_d;

  assign start = hdr_valid && hdr_sop;
  assign hold  = in_pkt_q || start;

  flex_cfg_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .N_SMP(N_SMP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .len_base(len_base), .len_shift(len_shift),
    .len_mode(len_mode), .len_off(len_off), .nxt_off(nxt_off),
    .len_mask(len_mask), .nxt_size(nxt_size), .in_arcs(in_arcs),
    .out_arcs(out_arcs), .smps(smps));

  flex_arc_sel #(.N(N_IN), .FLEX_NODE(FLEX_NODE)) u_in_sel (
    .arcs(in_arcs), .chk_node(1'b1), .key_node(up_node), .key_cmp(up_proto),
    .hit(in_hit), .sel_node(in_sel), .any_en());

  flex_arc_sel #(.N(N_OUT), .FLEX_NODE(FLEX_NODE)) u_out_sel (
    .arcs(out_arcs), .chk_node(1'b0), .key_node(in_sel), .key_cmp(nxt_type),
    .hit(out_hit), .sel_node(out_sel), .any_en(out_any));

  flex_word_tap #(.CNT_W(CNT_W)) u_len_tap (
    .clk(clk), .rst_n(rst_n), .byte_v(beat_ok), .sop(hdr_sop), .idx(idx),
    .off(len_off), .din(hdr_byte), .word(len_word));

  flex_word_tap #(.CNT_W(CNT_W)) u_nxt_tap (
    .clk(clk), .rst_n(rst_n), .byte_v(beat_ok), .sop(hdr_sop), .idx(idx),
    .off(nxt_off), .din(hdr_byte), .word(nxt_word));

  for (genvar g = 0; g < N_SMP; g++) begin : g_smp
    flex_word_tap #(.CNT_W(CNT_W)) u_tap (
      .clk(clk), .rst_n(rst_n), .byte_v(beat_ok), .sop(hdr_sop), .idx(idx),
      .off(smps[g].off), .din(hdr_byte), .word(smp_word[g]));
  end

  // Stream tracking: next state
  always_comb begin
    beat_ok  = hdr_valid && (hdr_sop || in_pkt_q);
    idx      = start ? '0 : cnt_q;
    in_pkt_d = beat_ok ? !hdr_eop : in_pkt_q;
    cnt_d    = beat_ok ? idx + 1'b1 : cnt_q;
    act_d    = start ? in_hit : act_q;
    fin_d    = beat_ok && hdr_eop && act_d;
  end

  // Result evaluation, one cycle after the last byte
  always_comb begin
    len_fld   = (len_word & len_mask) >> len_shift;
    hlen      = (len_mode == LEN_MODE_FIELD) ? 33'(len_base) + 33'(len_fld)
                                             : 33'(len_base);
    short_hdr = 33'(cnt_q) < hlen;
    nxt_rng   = (33'(nxt_off) + 33'd4) <= hlen;
    nxt_type  = 16'(nxt_word >> (6'd32 - {1'b0, nxt_size}));

    res_v_d    = fin_q;
    res_err_d  = fin_q && short_hdr;
    res_last_d = fin_q && !short_hdr && !out_any;
    res_hit_d  = fin_q && !short_hdr && nxt_rng && out_hit;
    res_node_d = res_hit_d ? out_sel : 8'd0;
    smp_data_d = '0;
    for (int i = 0; i < N_SMP; i++) begin
      smp_v_d[i] = fin_q && !short_hdr && smps[i].en &&
                   ((33'(smps[i].off) + 33'd4) <= hlen);
      if (smp_v_d[i]) smp_data_d[i*32 +: 32] = smp_word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0; act_q <= 1'b0; fin_q <= 1'b0; cnt_q <= '0;
      res_v    <= 1'b0; res_err <= 1'b0; res_last <= 1'b0; res_hit <= 1'b0;
      res_node <= '0;   smp_v   <= '0;   smp_data <= '0;
    end else begin
      in_pkt_q <= in_pkt_d; act_q <= act_d; fin_q <= fin_d; cnt_q <= cnt_d;
      res_v    <= res_v_d;  res_err <= res_err_d; res_last <= res_last_d;
      res_hit  <= res_hit_d; res_node <= res_node_d;
      smp_v    <= smp_v_d;  smp_data <= smp_data_d;
    end
  end
endmodule

// File: rtl/flex_hdr_parser_chk.sv
module flex_hdr_parser_chk #(
  parameter int N_SMP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_sop,
  input logic             hdr_eop,
  input logic             in_pkt,
  input logic [15:0]      len_base,
  input logic [31:0]      len_mask,
  input logic             res_v,
  input logic             res_err,
  input logic             res_last,
  input logic             res_hit,
  input logic [7:0]       res_node,
  input logic [N_SMP-1:0] smp_v
);
  assert_after_eop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> $past(hdr_valid && hdr_eop, 2));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res_err) |-> (smp_v == '0 && !res_hit && !res_last));

  assert_last_nohit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res_last) |-> !res_hit);

  assert_hit_node_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res_hit) |-> (res_node != 8'd0));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_v |-> (smp_v == '0 && !res_hit && !res_last && !res_err && res_node == 8'd0));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt || (hdr_valid && hdr_sop)) |=> ($stable(len_base) && $stable(len_mask)));
endmodule

bind flex_hdr_parser flex_hdr_parser_chk #(.N_SMP(N_SMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_sop(hdr_sop),
  .hdr_eop(hdr_eop), .in_pkt(in_pkt_q), .len_base(len_base),
  .len_mask(len_mask), .res_v(res_v), .res_err(res_err),
  .res_last(res_last), .res_hit(res_hit), .res_node(res_node),
  .smp_v(smp_v));

// File: tb/tb_flex_hdr_parser.sv
`timescale 1ns/1ps
module tb_flex_hdr_parser;
  typedef struct packed {
    logic         err;
    logic         last;
    logic         hit;
    logic [7:0]   node;
    logic [7:0]   sv;
    logic [255:0] sd;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, hdr_valid, hdr_sop, hdr_eop;
  logic [4:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [7:0] hdr_byte, up_node;
  logic [15:0] up_proto;
  logic res_v, res_err, res_last, res_hit;
  logic [7:0] res_node, smp_v;
  logic [255:0] smp_data;

  flex_hdr_parser dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_sop(hdr_sop),
    .hdr_eop(hdr_eop), .hdr_byte(hdr_byte), .up_node(up_node),
    .up_proto(up_proto), .res_v(res_v), .res_err(res_err),
    .res_last(res_last), .res_hit(res_hit), .res_node(res_node),
    .smp_v(smp_v), .smp_data(smp_data));

  int n_chk = 0, n_fail = 0, n_seen = 0;
  logic [7:0] pkt [64];
  exp_t eq [$];
  string tq [$];

  // Configuration mirror kept by the bench
  logic [15:0] m_base, m_len_off, m_nxt_off;
  logic [3:0]  m_shift, m_mode;
  logic [31:0] m_mask;
  logic [4:0]  m_size;
  logic [7:0]  m_in_node [8], m_out_node [8];
  logic [15:0] m_in_cmp [8], m_out_cmp [8], m_s_off [8];
  logic        m_s_en [8];

  function automatic void mirror(input logic [4:0] a, input logic [31:0] d);
    if (a == 5'd0) begin m_base = d[15:0]; m_shift = d[19:16]; m_mode = d[23:20]; end
    if (a == 5'd1) begin m_len_off = d[15:0]; m_nxt_off = d[31:16]; end
    if (a == 5'd2) m_mask = d;
    if (a == 5'd3) m_size = d[4:0];
    if (a >= 5'd8 && a < 5'd16) begin m_in_node[a-8] = d[7:0]; m_in_cmp[a-8] = d[23:8]; end
    if (a >= 5'd16 && a < 5'd24) begin m_out_node[a-16] = d[7:0]; m_out_cmp[a-16] = d[23:8]; end
    if (a >= 5'd24) begin m_s_off[a-24] = d[15:0]; m_s_en[a-24] = d[16]; end
  endfunction

  function automatic logic [31:0] wd(input int off, input int n);
    logic [31:0] w = 32'd0;
    for (int k = 0; k < 4; k++)
      if (off + k < n) w = {w[23:0], pkt[off+k]};
    return w;
  endfunction

  function automatic bit model(input logic [7:0] un, input logic [15:0] up,
                               input int n, output exp_t e);
    bit act = 0, any = 0, found = 0;
    longint hl;
    logic [31:0] lf, tw;
    logic [15:0] ty;
    logic [7:0] fnode = 8'd0;
    e = '0;
    for (int i = 0; i < 8; i++)
      if (m_in_node[i] != 0 && m_in_node[i] != 8'hF0 &&
          m_in_node[i] == un && m_in_cmp[i] == up) act = 1;
    if (!act) return 0;
    lf = (wd(int'(m_len_off), n) & m_mask) >> m_shift;
    hl = (m_mode == 4'd1) ? longint'(m_base) + longint'(lf) : longint'(m_base);
    e.err = (longint'(n) < hl);
    for (int i = 0; i < 8; i++)
      if (m_s_en[i] && longint'(m_s_off[i]) + 4 <= hl && !e.err) begin
        e.sv[i] = 1'b1;
        e.sd[i*32 +: 32] = wd(int'(m_s_off[i]), n);
      end
    tw = wd(int'(m_nxt_off), n);
    ty = (m_size == 0) ? 16'd0 : 16'(tw >> (32 - int'(m_size)));
    for (int i = 0; i < 8; i++) begin
      bit en = (m_out_node[i] != 0 && m_out_node[i] != 8'hF0);
      any |= en;
      if (en && !found && m_out_cmp[i] == ty) begin found = 1; fnode = m_out_node[i]; end
    end
    e.last = !e.err && !any;
    if (!e.err && longint'(m_nxt_off) + 4 <= hl && found) begin
      e.hit = 1'b1; e.node = fnode;
    end
    return 1;
  endfunction

  task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    mirror(a, d);
  endtask

  task automatic fill(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b3);
    for (int k = 0; k < 64; k++) pkt[k] = 8'(8'h40 + k);
    pkt[0] = b0; pkt[1] = b1; pkt[2] = 8'hAA; pkt[3] = b3;
    if (n < 0) $display("bad length");
  endtask

  // Driver: pushes the expected result, then streams the bytes
  task automatic send(input string tag, input logic [7:0] un, input logic [15:0] up,
                      input int n, input int wat, input logic [4:0] wa,
                      input logic [31:0] wdv);
    exp_t e;
    if (model(un, up, n, e)) begin eq.push_back(e); tq.push_back(tag); end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hdr_valid = 1'b1; hdr_sop = (k == 0); hdr_eop = (k == n - 1);
      hdr_byte = pkt[k]; up_node = un; up_proto = up;
      cfg_we = (k == wat);
      if (k == wat) begin cfg_addr = wa; cfg_wdata = wdv; end
    end
    @(negedge clk);
    hdr_valid = 1'b0; hdr_sop = 1'b0; hdr_eop = 1'b0; cfg_we = 1'b0;
    if (wat >= 0) mirror(wa, wdv);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_none(input string tag, input logic [7:0] un,
                           input logic [15:0] up, input int n);
    int s0 = n_seen;
    send(tag, un, up, n, -1, 5'd0, 32'd0);
    n_chk++;
    if (n_seen != s0) begin
      n_fail++;
      $display("FAIL %s: inactive header produced results: actual %0d expected 0", tag, n_seen - s0);
    end
  endtask

  // Monitor: pops and compares
  always @(negedge clk) begin
    exp_t e;
    string t;
    if (rst_n && res_v) begin
      n_seen++;
      n_chk++;
      if (eq.size() == 0) begin
        n_fail++;
        $display("FAIL R1/R4: unexpected result node=%h err=%b", res_node, res_err);
      end else begin
        e = eq.pop_front();
        t = tq.pop_front();
        if ({res_err, res_last, res_hit, res_node, smp_v, smp_data} !== e) begin
          n_fail++;
          $display("FAIL %s: actual err=%b last=%b hit=%b node=%h sv=%h sd=%h expected err=%b last=%b hit=%b node=%h sv=%h sd=%h",
                   t, res_err, res_last, res_hit, res_node, smp_v, smp_data,
                   e.err, e.last, e.hit, e.node, e.sv, e.sd);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    hdr_valid = 1'b0; hdr_sop = 1'b0; hdr_eop = 1'b0; hdr_byte = '0;
    up_node = '0; up_proto = '0;
    for (int i = 0; i < 32; i++) mirror(5'(i), 32'd0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    n_chk++;
    if ({res_v, res_err, res_last, res_hit, res_node, smp_v, smp_data} !== '0) begin
      n_fail++;
      $display("FAIL R11: outputs after reset actual v=%b node=%h sv=%h expected all zero",
               res_v, res_node, smp_v);
    end

    cfg_wr(5'd0, 32'h001E_0004);          // field mode, shift 14, base 4
    cfg_wr(5'd1, 32'h0000_0002);          // next offset 0, length offset 2
    cfg_wr(5'd2, 32'h00FF_0000);
    cfg_wr(5'd3, 32'd16);
    cfg_wr(5'd8, {8'h0, 16'h88B5, 8'h11});
    cfg_wr(5'd9, {8'h0, 16'h4444, 8'hF0}); // flex-to-flex arc: disabled
    cfg_wr(5'd16, {8'h0, 16'h0800, 8'h21});
    cfg_wr(5'd17, {8'h0, 16'h86DD, 8'h22});
    cfg_wr(5'd18, {8'h0, 16'h0800, 8'h23});
    cfg_wr(5'd24, {15'h0, 1'b1, 16'd4});
    cfg_wr(5'd25, {15'h0, 1'b1, 16'd8});
    cfg_wr(5'd26, {15'h0, 1'b0, 16'd0});
    cfg_wr(5'd27, {15'h0, 1'b1, 16'd12});
    cfg_wr(5'd31, {15'h0, 1'b1, 16'd100});

    fill(16, 8'h08, 8'h00, 8'h03);
    send("R3 R5 R6 R7 field length, samples, lowest arc wins", 8'h11, 16'h88B5, 16, -1, 5'd0, 32'd0);
    fill(14, 8'h86, 8'hDD, 8'h02);
    send("R6 R7 slot past length, second arc", 8'h11, 16'h88B5, 14, -1, 5'd0, 32'd0);
    fill(10, 8'h08, 8'h00, 8'h05);
    send("R9 short header", 8'h11, 16'h88B5, 10, -1, 5'd0, 32'd0);
    fill(12, 8'h99, 8'h99, 8'h02);
    send("R7 no output arc matches", 8'h11, 16'h88B5, 12, -1, 5'd0, 32'd0);

    fill(12, 8'h08, 8'h00, 8'h02);
    send_none("R1 compare value mismatch", 8'h11, 16'h1234, 12);
    send_none("R1 node type mismatch", 8'h12, 16'h88B5, 12);
    send_none("R2 flex node arc ignored", 8'hF0, 16'h4444, 12);
    send_none("R2 zero node arc ignored", 8'h00, 16'h0000, 12);

    cfg_wr(5'd3, 32'd4);
    cfg_wr(5'd19, {8'h0, 16'h000A, 8'h30});
    fill(12, 8'hA5, 8'h00, 8'h02);
    send("R7 four-bit next-header field", 8'h11, 16'h88B5, 12, -1, 5'd0, 32'd0);

    cfg_wr(5'd0, 32'h000E_0008);          // fixed mode, base 8
    fill(10, 8'h50, 8'h00, 8'h07);
    send("R3 fixed length mode", 8'h11, 16'h88B5, 10, -1, 5'd0, 32'd0);
    send("R10 write held during packet", 8'h11, 16'h88B5, 10, 3, 5'd0, 32'h000E_0014);
    send("R10 held write applied after packet", 8'h11, 16'h88B5, 10, -1, 5'd0, 32'd0);

    cfg_wr(5'd0, 32'h000E_0008);
    for (int i = 16; i < 20; i++) cfg_wr(5'(i), 32'd0);
    send("R8 no output arc enabled", 8'h11, 16'h88B5, 10, -1, 5'd0, 32'd0);

    repeat (5) @(negedge clk);
    n_chk++;
    if (eq.size() != 0) begin
      n_fail++;
      $display("FAIL R4: missing results actual %0d pending expected 0", eq.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule